// File: doc/BRIEF.md
# Base-Delta Cache Line Compressor

This block packs a 32-byte cache line into a smaller form when its contents cluster tightly around one value. The line is split into eight 32-bit words. The lowest word becomes a shared base, and every word, the base included, is written as a signed one-byte offset from that base. When all eight offsets fit, the result is a 12-byte record: the base, then the eight offset bytes. When any offset does not fit, the line is marked raw and passes through unchanged.

A separate expansion path takes a 12-byte record and rebuilds the eight words at once. Each offset is sign-extended and added to the base. Both paths are one layer of combinational logic feeding an output register, so each has one cycle of latency. Deciding whether a line compresses takes one subtraction and one range test per word.

Top module: `bdc_codec`

## Requirements
- R1: Word i of `in_line` is bits [32*i+31 : 32*i], so word 0 holds the lowest address. Word 0 is the base.
- R2: A line is compressible exactly when, for every word, (word - base) taken modulo 2^32 and read as a signed 32-bit value lies in -128..+127.
- R3: A compressed result has `out_compressed`=1 and `out_size`=12. In `out_payload`, bits [31:0] hold the base, bits [32+8*i +: 8] hold the low byte of word i's offset, and bits [255:96] are zero.
- R4: In a compressed result the offset of word 0 (bits [39:32]) is always 0x00.
- R5: An incompressible line gives `out_compressed`=0, `out_size`=32, and `out_payload` equal to the input line.
- R6: `out_valid` equals `in_valid` of the previous cycle. Payload, flag and size change only on a cycle after `in_valid`, and otherwise hold.
- R7: Expansion: one cycle after `dec_valid`, `dec_out_valid`=1 and word i of `dec_line` = base + sign-extended offset i, modulo 2^32. The base is `dec_packed[31:0]` and offset i is `dec_packed[32+8*i +: 8]`.
- R8: Synchronous active-high `rst` clears both valid outputs, both data outputs and the flag, and sets `out_size` to zero.
- R9: Offsets wrap modulo 2^32. A base of 0xFFFFFFF0 with a word of 0x00000005 compresses, with offset 0x15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Line to compress is present |
| in_line | input | 256 | Line to compress, word 0 in the low bits |
| out_valid | output | 1 | Compression result valid |
| out_compressed | output | 1 | 1 = packed record, 0 = raw line |
| out_size | output | 6 | Result size in bytes (12 or 32) |
| out_payload | output | 256 | Packed record in the low 96 bits, or the raw line |
| dec_valid | input | 1 | Record to expand is present |
| dec_packed | input | 96 | Base in the low 32 bits, then eight offset bytes |
| dec_out_valid | output | 1 | Expanded line valid |
| dec_line | output | 256 | Expanded line |

## Verification
The assertions take for granted that `in_valid` and `dec_valid` are held low while `rst` is high. The pass-through and base checks compare against the previous cycle's `in_line`, so they also rely on inputs being defined whenever a valid is raised. The bench drives inputs only on falling edges, keeps every valid low through reset, and returns valids to zero after each one-cycle request. Its lines are built from a chosen base plus offsets placed on each side of the -128..+127 boundary, together with a wrap case near 2^32.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
    localparam int WORDS   = 8;
    localparam int WORD_W  = 32;
    localparam int DELTA_W = 8;
    localparam int LINE_W  = WORDS * WORD_W;
    localparam int PACK_W  = WORD_W + WORDS * DELTA_W;
    localparam int SIZE_W  = 6;
    localparam logic [SIZE_W-1:0] SIZE_RAW    = SIZE_W'(LINE_W / 8);
    localparam logic [SIZE_W-1:0] SIZE_PACKED = SIZE_W'(PACK_W / 8);

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [DELTA_W-1:0] delta_t;
    typedef logic [LINE_W-1:0]  line_t;

    // base occupies the low bits, offsets follow in word order
    typedef struct packed {
        delta_t [WORDS-1:0] deltas;
        word_t              base;
    } packed_t;

    // a difference fits when all bits above the offset sign bit copy it
    function automatic logic fits_delta(input word_t diff);
        return (&diff[WORD_W-1:DELTA_W-1]) || !(|diff[WORD_W-1:DELTA_W-1]);
    endfunction

    function automatic word_t sext_delta(input delta_t d);
        return {{(WORD_W-DELTA_W){d[DELTA_W-1]}}, d};
    endfunction
endpackage

// File: rtl/bdc_delta_fit.sv
module bdc_delta_fit
    import bdc_pkg::*;
(
    input  word_t  base,
    input  word_t  word,
    output delta_t delta,
    output logic   fit
);
    word_t diff;
    always_comb begin
        diff  = word - base;
        delta = diff[DELTA_W-1:0];
        fit   = fits_delta(diff);
    end
endmodule

// File: rtl/bdc_encoder.sv
module bdc_encoder
    import bdc_pkg::*;
(
    input  line_t line,
    output logic  compressed,
    output line_t payload
);
    logic [WORDS-1:0] fit;
    packed_t          rec;

    assign rec.base = line[WORD_W-1:0];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        bdc_delta_fit u_fit (
            .base  (line[WORD_W-1:0]),
            .word  (line[i*WORD_W +: WORD_W]),
            .delta (rec.deltas[i]),
            .fit   (fit[i])
        );
    end

    always_comb begin
        compressed = &fit;
        payload    = compressed ? {{(LINE_W-PACK_W){1'b0}}, rec} : line;
    end
endmodule

// File: rtl/bdc_decoder.sv
module bdc_decoder
    import bdc_pkg::*;
(
    input  packed_t rec,
    output line_t   line
);
    for (genvar i = 0; i < WORDS; i++) begin : g_word
        assign line[i*WORD_W +: WORD_W] = rec.base + sext_delta(rec.deltas[i]);
    end
endmodule

// File: rtl/bdc_codec.sv
module bdc_codec
    import bdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [LINE_W-1:0] in_line,
    output logic              out_valid,
    output logic              out_compressed,
    output logic [SIZE_W-1:0] out_size,
    output logic [LINE_W-1:0] out_payload,
    input  logic              dec_valid,
    input  logic [PACK_W-1:0] dec_packed,
    output logic              dec_out_valid,
    output logic [LINE_W-1:0] dec_line
);
    logic    enc_compressed;
    line_t   enc_payload;
    line_t   dec_comb;
    packed_t dec_rec;

    assign dec_rec = packed_t'(dec_packed);

    bdc_encoder u_enc (
        .line       (in_line),
        .compressed (enc_compressed),
        .payload    (enc_payload)
    );

    bdc_decoder u_dec (
        .rec  (dec_rec),
        .line (dec_comb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid      <= 1'b0;
            out_compressed <= 1'b0;
            out_size       <= '0;
            out_payload    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_compressed <= enc_compressed;
                out_size       <= enc_compressed ? SIZE_PACKED : SIZE_RAW;
                out_payload    <= enc_payload;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_out_valid <= 1'b0;
            dec_line      <= '0;
        end else begin
            dec_out_valid <= dec_valid;
            if (dec_valid) dec_line <= dec_comb;
        end
    end
endmodule

// File: rtl/bdc_codec_chk.sv
module bdc_codec_chk
    import bdc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [LINE_W-1:0] in_line,
    input logic              out_valid,
    input logic              out_compressed,
    input logic [SIZE_W-1:0] out_size,
    input logic [LINE_W-1:0] out_payload,
    input logic              dec_valid,
    input logic [PACK_W-1:0] dec_packed,
    input logic              dec_out_valid,
    input logic [LINE_W-1:0] dec_line
);
    assert_base_field_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (!out_compressed || out_payload[WORD_W-1:0] == $past(in_line[WORD_W-1:0])));

    assert_packed_shape_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_compressed) |-> (out_size == SIZE_PACKED && out_payload[LINE_W-1:PACK_W] == '0));

    assert_first_delta_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_compressed) |-> out_payload[WORD_W +: DELTA_W] == '0);

    assert_raw_passthru_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_compressed || (out_payload == $past(in_line) && out_size == SIZE_RAW)));

    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_payload) && $stable(out_compressed)));

    assert_dec_latency_R7: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> dec_out_valid);

    assert_dec_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |=> (!dec_out_valid && $stable(dec_line)));

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> (!out_valid && !dec_out_valid && out_payload == '0 && dec_line == '0));
endmodule

bind bdc_codec bdc_codec_chk u_chk (.*);

// File: tb/tb_bdc_codec.sv
`timescale 1ns/1ps
module tb_bdc_codec;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [255:0] in_line;
    logic         out_valid, out_compressed, dec_valid, dec_out_valid;
    logic [5:0]   out_size;
    logic [255:0] out_payload, dec_line;
    logic [95:0]  dec_packed;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bdc_codec dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_line(in_line),
        .out_valid(out_valid), .out_compressed(out_compressed),
        .out_size(out_size), .out_payload(out_payload),
        .dec_valid(dec_valid), .dec_packed(dec_packed),
        .dec_out_valid(dec_out_valid), .dec_line(dec_line)
    );

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // independent model: signed integer offsets per word
    task automatic model(input logic [255:0] line, output logic c, output logic [255:0] p);
        logic [31:0] b;
        b = line[31:0];
        c = 1'b1;
        p = '0;
        p[31:0] = b;
        for (int i = 0; i < 8; i++) begin
            logic [31:0] d;
            int sd;
            d  = line[32*i +: 32] - b;
            sd = int'(signed'(d));
            if (sd < -128 || sd > 127) c = 1'b0;
            p[32 + 8*i +: 8] = d[7:0];
        end
        if (!c) p = line;
    endtask

    function automatic logic [255:0] mk_line(input logic [31:0] b, input int off [8]);
        logic [255:0] l;
        for (int i = 0; i < 8; i++) l[32*i +: 32] = b + 32'(off[i]);
        return l;
    endfunction

    task automatic compress(input logic [255:0] line, input string tag);
        logic ec;
        logic [255:0] ep;
        model(line, ec, ep);
        @(negedge clk);
        in_valid = 1'b1;
        in_line  = line;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, {tag, " R6 valid"}, 256'(out_valid), 256'd1);
        chk(out_compressed == ec, {tag, " flag R2"}, 256'(out_compressed), 256'(ec));
        chk(out_size == (ec ? 6'd12 : 6'd32), {tag, " size R3/R5"}, 256'(out_size), ec ? 256'd12 : 256'd32);
        chk(out_payload == ep, {tag, " payload R3/R5"}, out_payload, ep);
    endtask

    task automatic expand(input logic [95:0] rec, input logic [255:0] exp, input string tag);
        @(negedge clk);
        dec_valid  = 1'b1;
        dec_packed = rec;
        @(negedge clk);
        dec_valid = 1'b0;
        chk(dec_out_valid == 1'b1, {tag, " R7 valid"}, 256'(dec_out_valid), 256'd1);
        chk(dec_line == exp, {tag, " R7 line"}, dec_line, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 0 && dec_out_valid == 0, "R8 valids", 256'({out_valid, dec_out_valid}), 256'd0);
        chk(out_payload == '0 && out_size == 0, "R8 payload", out_payload, 256'd0);
        chk(dec_line == '0, "R8 dec_line", dec_line, 256'd0);
    endtask

    task automatic t_stride();
        int off [8] = '{0, 8, 16, 24, 32, 40, 48, 56};
        logic [255:0] l;
        l = mk_line(32'hC04039C0, off);
        compress(l, "stride");
        chk(out_payload[31:0] == 32'hC04039C0, "R1 base", 256'(out_payload[31:0]), 256'hC04039C0);
        chk(out_payload[39:32] == 8'h00, "R4 delta0", 256'(out_payload[39:32]), 256'd0);
        chk(out_payload[95:88] == 8'h38, "R3 delta7", 256'(out_payload[95:88]), 256'h38);
    endtask

    task automatic t_bounds();
        int ok_off [8]  = '{0, 127, -128, 5, -5, 100, -100, 1};
        int hi_off [8]  = '{0, 1, 2, 3, 4, 5, 6, 128};
        int lo_off [8]  = '{0, -129, 2, 3, 4, 5, 6, 7};
        logic [255:0] l;
        l = mk_line(32'h1234_5678, ok_off);
        compress(l, "edges-in R2");
        chk(out_compressed == 1'b1, "R2 +127/-128 fit", 256'(out_compressed), 256'd1);
        l = mk_line(32'h1234_5678, hi_off);
        compress(l, "plus128 R5");
        chk(out_payload == l, "R5 raw +128 word7 R1", out_payload, l);
        l = mk_line(32'h1234_5678, lo_off);
        compress(l, "minus129 R5");
        chk(out_compressed == 1'b0, "R2 -129 rejects", 256'(out_compressed), 256'd0);
    endtask

    task automatic t_wrap();
        logic [255:0] l;
        l = {7{32'hFFFF_FFF0}};
        l = {l[223:0], 32'hFFFF_FFF0};
        l[63:32] = 32'h0000_0005;
        compress(l, "wrap R9");
        chk(out_compressed == 1'b1 && out_payload[47:40] == 8'h15, "R9 wrap offset",
            256'(out_payload[47:40]), 256'h15);
    endtask

    task automatic t_hold();
        logic [255:0] held;
        held = out_payload;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R6 idle valid low", 256'(out_valid), 256'd0);
        chk(out_payload == held, "R6 idle hold", out_payload, held);
    endtask

    task automatic t_expand();
        logic [95:0]  rec;
        logic [255:0] exp;
        int off [8] = '{0, 127, -128, -1, 1, 64, -64, 2};
        rec[31:0] = 32'h0000_0040;
        for (int i = 0; i < 8; i++) rec[32 + 8*i +: 8] = 8'(off[i]);
        exp = mk_line(32'h0000_0040, off);
        expand(rec, exp, "sext");
    endtask

    task automatic t_roundtrip();
        for (int n = 0; n < 24; n++) begin
            int off [8];
            logic [255:0] l;
            logic [31:0] b;
            b = $urandom;
            for (int i = 0; i < 8; i++) off[i] = (i == 0) ? 0 : int'($urandom % 300) - 150;
            l = mk_line(b, off);
            compress(l, "random");
            if (out_compressed) expand(out_payload[95:0], l, "roundtrip R7");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R6 actual=hang expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_line = '0; dec_valid = 1'b0; dec_packed = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_stride();
        t_hold();
        t_bounds();
        t_wrap();
        t_expand();
        t_roundtrip();
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule